// File: doc/BRIEF.md
# Processor interrupt presenter

This block sits between an interrupt source controller and one processor. It keeps the processor's current priority threshold, the priority of the pending inter-processor interrupt request, a single pending source slot with its priority, and a flag that records that a delivery was turned away. Lower numbers are more favored. The source side offers interrupts. The block accepts an offer, refuses it, or accepts it and hands back the source it displaced. It drives one interrupt line to the processor.

The processor works the block through four commands on one command port: accept (read the pending word), set priority threshold, set inter-processor request priority, and end-of-interrupt. The block returns displaced sources for re-delivery. When a threshold or request-priority change opens a window for refused work, it pulses a resend request. It forwards end-of-interrupt source numbers to the source side. Each command or offer updates all state in one clock cycle. Every reply is registered and appears for one cycle after the edge that did the work.

Top module: `irq_presenter`

## Requirements
- R1: After reset the threshold is 0x00, the request priority is 0xFF, the pending priority is 0xFF, the pending source is 0, the refused flag is clear and irq_out is low. An accept issued right after reset returns 0x00000000.
- R2: An offer at priority p is accepted (offer_ack pulses) only when p is strictly below the threshold, the request priority and the pending priority. The pending source then takes the offered source and the pending priority takes p. A non-zero displaced source is reported on rej_valid/rej_src.
- R3: A refused offer pulses offer_nak, sets the refused flag and leaves the pending slot unchanged.
- R4: irq_out is high exactly when the pending source is non-zero and the pending priority is below the threshold.
- R5: Accept (cmd_op 0) returns on rd_data {threshold[31:24], pending source[23:0]} with rd_valid. If the pending source was non-zero, the threshold takes the pending priority, the pending priority becomes 0xFF and the slot clears.
- R6: Set request priority (cmd_op 2, value in cmd_data[7:0]) loads it. If the value is below the threshold and at or below the pending priority, the pending source is displaced and the inter-processor source number is installed at that priority.
- R7: When set request priority raises the value above its old one, the refused flag goes out as a resend_pulse and is cleared.
- R8: Set threshold (cmd_op 1, value in cmd_data[7:0]) to a larger value loads it. If the request priority is below the new threshold and at or below the pending priority, the inter-processor source is installed at the request priority. The refused flag goes out as resend_pulse and clears.
- R9: Set threshold to an equal value changes nothing and sends no pulse. To a smaller value it loads the threshold, and if the new value is at or below the pending priority, the pending source is displaced, the slot clears and the pending priority becomes 0xFF.
- R10: End-of-interrupt (cmd_op 3) applies the larger-value threshold rule of R8 with cmd_data[31:24]. It forwards cmd_data[23:0] on eoi_valid/eoi_src unless that equals the inter-processor source number.
- R11: The inter-processor source number is 2. A displaced source equal to 2, or equal to 0, is never reported on rej_valid.
- R12: A command takes priority over an offer in the same cycle. offer_ready is low while cmd_valid is high, and an offer presented then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 2 | 0 accept, 1 set threshold, 2 set request priority, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| rd_valid | output | 1 | Accept result valid |
| rd_data | output | 32 | Accept result word |
| offer_valid | input | 1 | Source side offers an interrupt |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_ready | output | 1 | Offer will be evaluated this cycle |
| offer_ack | output | 1 | Offer accepted |
| offer_nak | output | 1 | Offer refused |
| rej_valid | output | 1 | A displaced source is returned |
| rej_src | output | 24 | Displaced source number |
| resend_pulse | output | 1 | Source side should retry refused work |
| eoi_valid | output | 1 | End-of-interrupt forwarded |
| eoi_src | output | 24 | Source whose service ended |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
On every cycle the assertions check that accept and refuse never coincide, that displaced and end-of-interrupt numbers are never the inter-processor source, that replies only follow an evaluated event, and that a non-empty accept leaves the line low. The priority comparisons can only be shown by the bench's directed scenarios: strict versus equal offers, installing the inter-processor request through either threshold or request-priority changes, and suppressing the pulse on an equal threshold write. Command-over-offer arbitration is also shown there.

// File: rtl/irqp_pkg.sv
// Package: shared widths, command codes, state and reply records, and the
// threshold-lowering-favor rule used by two commands.
package irqp_pkg;
    localparam int PRIO_W  = 8;
    localparam int SRC_W   = 24;
    localparam int WORD_W  = PRIO_W + SRC_W;
    localparam logic [SRC_W-1:0] IPI_SRC = SRC_W'(2);

    typedef enum logic [1:0] {
        OP_ACCEPT   = 2'd0,
        OP_SET_THR  = 2'd1,
        OP_SET_REQ  = 2'd2,
        OP_EOI      = 2'd3
    } op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] thr;
        logic [PRIO_W-1:0] req;
        logic [PRIO_W-1:0] pend;
        logic [SRC_W-1:0]  src;
        logic              refused;
    } state_t;

    typedef struct packed {
        logic              ack;
        logic              nak;
        logic              rej_v;
        logic [SRC_W-1:0]  rej_src;
        logic              resend;
        logic              eoi_v;
        logic [SRC_W-1:0]  eoi_src;
        logic              rd_v;
        logic [WORD_W-1:0] rdata;
    } reply_t;

    // Threshold made less favored: load it, maybe install the IPI, drop the flag.
    function automatic state_t thr_down(state_t s, logic [PRIO_W-1:0] t);
        state_t n;
        n = s;
        n.thr = t;
        if (s.req < t && s.req <= s.pend) begin
            n.pend = s.req;
            n.src  = IPI_SRC;
        end
        n.refused = 1'b0;
        return n;
    endfunction
endpackage

// File: rtl/irqp_next.sv
// Module: irqp_next
// Computes next state and the reply record for one event per cycle.
// Assumes a command wins over an offer presented in the same cycle.
module irqp_next
    import irqp_pkg::*;
#(
    parameter int P_W = PRIO_W,
    parameter int S_W = SRC_W
) (
    input  state_t           cur,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [P_W+S_W-1:0] cmd_data,
    input  logic             offer_valid,
    input  logic [S_W-1:0]   offer_src,
    input  logic [P_W-1:0]   offer_prio,
    output state_t           nxt,
    output reply_t           rsp
);
    localparam int TOP = P_W + S_W;

    logic [S_W-1:0] displaced;
    logic [P_W-1:0] val;
    logic [P_W-1:0] eoi_thr;
    logic [S_W-1:0] eoi_id;

    assign val     = cmd_data[P_W-1:0];
    assign eoi_thr = cmd_data[TOP-1:S_W];
    assign eoi_id  = cmd_data[S_W-1:0];

    // Evaluate the selected event against the current state.
    always_comb begin
        nxt       = cur;
        rsp       = '0;
        displaced = '0;
        if (cmd_valid) begin
            unique case (op_e'(cmd_op))
                OP_ACCEPT: begin
                    rsp.rd_v  = 1'b1;
                    rsp.rdata = {cur.thr, cur.src};
                    if (cur.src != '0) begin
                        nxt.thr  = cur.pend;
                        nxt.pend = '1;
                        nxt.src  = '0;
                    end
                end
                OP_SET_THR: begin
                    if (val > cur.thr) begin
                        nxt        = thr_down(cur, val);
                        rsp.resend = cur.refused;
                    end else if (val < cur.thr) begin
                        nxt.thr = val;
                        if (val <= cur.pend) begin
                            displaced = cur.src;
                            nxt.src   = '0;
                            nxt.pend  = '1;
                        end
                    end
                end
                OP_SET_REQ: begin
                    nxt.req = val;
                    if (val < cur.thr && val <= cur.pend) begin
                        displaced = cur.src;
                        nxt.pend  = val;
                        nxt.src   = IPI_SRC;
                    end
                    if (val > cur.req) begin
                        rsp.resend  = cur.refused;
                        nxt.refused = 1'b0;
                    end
                end
                default: begin
                    nxt        = thr_down(cur, eoi_thr);
                    rsp.resend = cur.refused;
                    if (eoi_id != IPI_SRC) begin
                        rsp.eoi_v   = 1'b1;
                        rsp.eoi_src = eoi_id;
                    end
                end
            endcase
        end else if (offer_valid) begin
            if (offer_prio < cur.thr && offer_prio < cur.req && offer_prio < cur.pend) begin
                rsp.ack   = 1'b1;
                displaced = cur.src;
                nxt.src   = offer_src;
                nxt.pend  = offer_prio;
            end else begin
                rsp.nak     = 1'b1;
                nxt.refused = 1'b1;
            end
        end
        rsp.rej_v   = (displaced != '0) && (displaced != IPI_SRC);
        rsp.rej_src = displaced;
    end
endmodule

// File: rtl/irqp_regs.sv
// Module: irqp_regs
// Holds presenter state and the registered reply record.
// Assumes synchronous active-low reset.
module irqp_regs
    import irqp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_t nxt,
    input  reply_t rsp_d,
    output state_t cur,
    output reply_t rsp_q
);
    // State and reply flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur.thr     <= '0;
            cur.req     <= '1;
            cur.pend    <= '1;
            cur.src     <= '0;
            cur.refused <= 1'b0;
            rsp_q       <= '0;
        end else begin
            cur   <= nxt;
            rsp_q <= rsp_d;
        end
    end

    AST_ACK_NAK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_q.ack && rsp_q.nak)); // R2
    AST_REJ_NOT_IPI: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_q.rej_v |-> (rsp_q.rej_src != IPI_SRC && rsp_q.rej_src != '0)); // R11
    AST_EOI_NOT_IPI: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_q.eoi_v |-> rsp_q.eoi_src != IPI_SRC); // R10
endmodule

// File: rtl/irq_presenter.sv
// Module: irq_presenter (top)
// Per-processor interrupt presenter: single pending slot, priority threshold,
// inter-processor request priority, refused-offer flag. One event per cycle.
module irq_presenter
    import irqp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    input  logic              offer_valid,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_prio,
    output logic              offer_ready,
    output logic              offer_ack,
    output logic              offer_nak,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              resend_pulse,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              irq_out
);
    state_t cur, nxt;
    reply_t rsp_d, rsp_q;

    irqp_next #(.P_W(PRIO_W), .S_W(SRC_W)) next_i (
        .cur(cur), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .nxt(nxt), .rsp(rsp_d)
    );

    irqp_regs regs_i (
        .clk(clk), .rst_n(rst_n), .nxt(nxt), .rsp_d(rsp_d),
        .cur(cur), .rsp_q(rsp_q)
    );

    // Output mapping and interrupt line.
    assign offer_ready  = !cmd_valid;
    assign offer_ack    = rsp_q.ack;
    assign offer_nak    = rsp_q.nak;
    assign rej_valid    = rsp_q.rej_v;
    assign rej_src      = rsp_q.rej_src;
    assign resend_pulse = rsp_q.resend;
    assign eoi_valid    = rsp_q.eoi_v;
    assign eoi_src      = rsp_q.eoi_src;
    assign rd_valid     = rsp_q.rd_v;
    assign rd_data      = rsp_q.rdata;
    assign irq_out      = (cur.src != '0) && (cur.pend < cur.thr);

    AST_REPLY_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_ack || offer_nak) |-> $past(offer_valid && !cmd_valid)); // R12
    AST_ACCEPT_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_data[SRC_W-1:0] != '0) |-> !irq_out); // R5
    AST_RESEND_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        resend_pulse |-> $past(cmd_valid)); // R7
endmodule

// File: tb/irq_presenter_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module irq_presenter_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0;
    logic [1:0]  cmd_op = 0;
    logic [31:0] cmd_data = 0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        offer_valid = 0;
    logic [23:0] offer_src = 0;
    logic [7:0]  offer_prio = 0;
    logic        offer_ready, offer_ack, offer_nak, rej_valid, resend_pulse, eoi_valid, irq_out;
    logic [23:0] rej_src, eoi_src;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_presenter dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .offer_valid(offer_valid), .offer_src(offer_src),
        .offer_prio(offer_prio), .offer_ready(offer_ready), .offer_ack(offer_ack),
        .offer_nak(offer_nak), .rej_valid(rej_valid), .rej_src(rej_src),
        .resend_pulse(resend_pulse), .eoi_valid(eoi_valid), .eoi_src(eoi_src), .irq_out(irq_out)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] op, input logic [31:0] d);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic offer(input logic [23:0] s, input logic [7:0] p);
        @(negedge clk);
        offer_valid = 1; offer_src = s; offer_prio = p;
        @(negedge clk);
        offer_valid = 0;
    endtask

    task automatic t_reset;
        check("R1 irq after reset", irq_out, 0);
        cmd(0, 0);
        check("R1 accept after reset", rd_data, 32'h0000_0000);
        check("R5 rd_valid", rd_valid, 1);
    endtask

    task automatic t_offers;
        cmd(1, 32'hFF);
        check("R8 no resend", resend_pulse, 0);
        offer(24'h10, 8'd5);
        check("R2 ack", offer_ack, 1);
        check("R2 no reject of empty", rej_valid, 0);
        check("R4 irq high", irq_out, 1);
        offer(24'h20, 8'd5);
        check("R3 nak equal prio", offer_nak, 1);
        check("R3 slot kept", irq_out, 1);
        offer(24'h21, 8'd3);
        check("R2 ack better", offer_ack, 1);
        check("R2 reject valid", rej_valid, 1);
        check("R2 reject src", rej_src, 24'h10);
    endtask

    task automatic t_accept_eoi;
        cmd(0, 0);
        check("R5 accept word", rd_data, 32'hFF00_0021);
        check("R5 irq low", irq_out, 0);
        cmd(0, 0);
        check("R5 threshold from pend", rd_data, 32'h0300_0000);
        offer(24'h22, 8'd4);
        check("R3 nak vs threshold", offer_nak, 1);
        cmd(3, 32'hFF00_0021);
        check("R10 resend on eoi", resend_pulse, 1);
        check("R10 eoi valid", eoi_valid, 1);
        check("R10 eoi src", eoi_src, 24'h21);
        cmd(3, 32'hFF00_0002);
        check("R11 ipi eoi not forwarded", eoi_valid, 0);
        check("R10 flag already clear", resend_pulse, 0);
    endtask

    task automatic t_req;
        cmd(2, 32'h06);
        check("R6 ipi raises irq", irq_out, 1);
        check("R6 no reject of empty", rej_valid, 0);
        cmd(0, 0);
        check("R6 ipi word", rd_data, 32'hFF00_0002);
        offer(24'h30, 8'd5);
        check("R2 ack under req", offer_ack, 1);
        cmd(2, 32'h04);
        check("R6 reject on ipi", rej_valid, 1);
        check("R6 reject src", rej_src, 24'h30);
        offer(24'h31, 8'd7);
        check("R3 nak", offer_nak, 1);
        cmd(2, 32'hFF);
        check("R7 resend on raise", resend_pulse, 1);
        check("R4 ipi still pending", irq_out, 1);
    endtask

    task automatic t_thr;
        cmd(1, 32'h03);
        check("R11 ipi not rejected", rej_valid, 0);
        check("R9 irq low", irq_out, 0);
        cmd(0, 0);
        check("R9 slot cleared", rd_data, 32'h0300_0000);
        offer(24'h40, 8'd3);
        check("R3 nak equal thr", offer_nak, 1);
        cmd(1, 32'h03);
        check("R9 equal no resend", resend_pulse, 0);
        cmd(1, 32'h80);
        check("R8 resend on larger", resend_pulse, 1);
        cmd(1, 32'h10);
        cmd(2, 32'h40);
        check("R6 no ipi above thr", irq_out, 0);
        cmd(1, 32'h50);
        check("R8 ipi installed", irq_out, 1);
        cmd(0, 0);
        check("R8 ipi word", rd_data, 32'h5000_0002);
    endtask

    task automatic t_arb;
        @(negedge clk);
        cmd_valid = 1; cmd_op = 0; cmd_data = 0;
        offer_valid = 1; offer_src = 24'h50; offer_prio = 8'd1;
        #1 check("R12 ready low", offer_ready, 0);
        @(negedge clk);
        cmd_valid = 0; offer_valid = 0;
        check("R12 no ack", offer_ack, 0);
        check("R12 no nak", offer_nak, 0);
        cmd(0, 0);
        check("R12 offer dropped", rd_data, 32'h4000_0000);
        offer(24'h60, 8'h20);
        check("R2 ack", offer_ack, 1);
        cmd(1, 32'h20);
        check("R9 reject on lower thr", rej_src, 24'h60);
        check("R9 reject valid", rej_valid, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_offers();
        t_accept_eoi();
        t_req();
        t_thr();
        t_arb();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule